// File: doc/BRIEF.md
# Advanced Load Address Table

This block keeps track of data-speculative loads that are still outstanding. Each entry pairs a target register number with the physical address and byte count of the load that filled it. When the load is later confirmed by a check operation, the table reports whether the earlier value is still good. If it is, the destination can be left alone and no memory access is needed. If it is not, the caller must reissue the load.

The block has one request port. The caller presents an operation code, a target register index, an address, a byte count, a page attribute marking non-speculative data and a deferral flag. The response comes back combinationally in the same cycle, and the table state changes on the next clock edge. A separate snoop port carries the address and byte count of each store; any entry whose byte range the store touches is dropped. A forced-miss input lets the surrounding core make every check fail. A flush input empties the table in one cycle.

Top module: `adv_load_tracker`

## Requirements
- R1: Operation codes are 0 plain load, 1 advanced load, 2 speculative advanced load, 3 keeping check, 4 clearing check, 5 ordered clearing check, 6 ordered load and 7 plain load. An advanced load (code 1 or 2) with the deferral flag low allocates an entry for its register and address. It responds with load=1, hit=0 and keep=0.
- R2: An advanced load with the deferral flag high removes every entry held for its target register, whatever the address. It allocates nothing and responds with load=0, hit=0 and keep=0.
- R3: A keeping check that finds a matching entry responds with hit=1, load=0 and keep=1. The entry stays, so a repeat of the same check hits again.
- R4: A keeping check that misses responds with load=1, hit=0 and keep=0. It allocates an entry unless the non-speculative attribute is 1, in which case it allocates nothing.
- R5: A clearing check (code 4) that hits removes the entry and responds with hit=1, load=0 and keep=1. On a miss it responds with load=1 and allocates nothing.
- R6: The acquire output is 1 for the ordered clearing check (code 5) and the ordered load (code 6), and 0 for every other code. Code 5 otherwise behaves exactly like code 4.
- R7: While the force-miss input is 1, every check reports a miss and is handled as a miss.
- R8: The base-update output is 1 for all three check codes, whether they hit or miss, and 0 for every other code.
- R9: A lookup matches only a valid entry whose register index, address and byte count all equal those of the request.
- R10: A store snoop drops every entry whose byte range [addr, addr+size) overlaps the store's range. A lookup in the same cycle sees the table with the store already applied.
- R11: Reset and the flush input both empty the table, and flush also returns the victim pointer to entry 0. A lookup in a flush cycle misses, and nothing is allocated in that cycle.
- R12: An allocation reuses the entry that already holds its register. Otherwise it takes the lowest free entry. When the table is full it replaces the entry named by a round-robin pointer, which then moves on by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Empty the whole table |
| force_miss_i | input | 1 | Make every check lookup miss |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 3 | Operation code |
| req_reg_i | input | REG_W (7) | Target register index |
| req_addr_i | input | ADDR_W (32) | Physical address |
| req_size_i | input | SIZE_W (4) | Access size in bytes |
| req_nonspec_i | input | 1 | Page holds non-speculative data |
| req_defer_i | input | 1 | Advanced load was deferred |
| snp_valid_i | input | 1 | Store snoop present |
| snp_addr_i | input | ADDR_W (32) | Store address |
| snp_size_i | input | SIZE_W (4) | Store size in bytes |
| rsp_valid_o | output | 1 | Response valid, equal to the request valid |
| rsp_hit_o | output | 1 | Check lookup hit |
| rsp_load_o | output | 1 | Memory load must be performed |
| rsp_keep_o | output | 1 | Destination register stays unchanged |
| rsp_base_upd_o | output | 1 | Base-register update applies |
| rsp_acq_o | output | 1 | Acquire ordering applies |

## Verification
Most internal faults show up on the next check that names the affected register. A lost valid bit turns an expected hit into a reload. A stale entry turns a required reload into a hit, which means stale data would be consumed silently. These faults surface at the first later lookup, one cycle after the corrupting operation at the earliest, but they can stay hidden until then. For that reason the tests follow each table update with a probe check. Victim-pointer faults appear only after the table has been filled and then overfilled, so the allocation test probes exactly which register was evicted.

// File: rtl/alt_pkg.sv
package alt_pkg;

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_ADV      = 3'd1,
    OP_SADV     = 3'd2,
    OP_CHK_KEEP = 3'd3,
    OP_CHK_CLR  = 3'd4,
    OP_CHK_ACQ  = 3'd5,
    OP_ORD_LOAD = 3'd6,
    OP_LOAD_ALT = 3'd7
  } alt_op_e;

  function automatic logic op_is_adv(input logic [2:0] op);
    return (op == OP_ADV) || (op == OP_SADV);
  endfunction

  function automatic logic op_is_chk(input logic [2:0] op);
    return (op == OP_CHK_KEEP) || (op == OP_CHK_CLR) || (op == OP_CHK_ACQ);
  endfunction

  function automatic logic op_is_clr(input logic [2:0] op);
    return (op == OP_CHK_CLR) || (op == OP_CHK_ACQ);
  endfunction

endpackage

// File: rtl/alt_entry_cmp.sv
module alt_entry_cmp #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int REG_W  = 7
) (
  input  logic              ent_valid,
  input  logic [REG_W-1:0]  ent_reg,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [SIZE_W-1:0] snp_size,
  output logic              reg_eq,
  output logic              tag_eq,
  output logic              snp_hit
);

  localparam int EXT_W = ADDR_W + 1;
  localparam int PAD_W = EXT_W - SIZE_W;

  logic [EXT_W-1:0] ent_lo, ent_hi, snp_lo, snp_hi;

  // One extra bit keeps the range ends from wrapping at the top of memory.
  always_comb begin
    ent_lo = {1'b0, ent_addr};
    ent_hi = ent_lo + {{PAD_W{1'b0}}, ent_size};
    snp_lo = {1'b0, snp_addr};
    snp_hi = snp_lo + {{PAD_W{1'b0}}, snp_size};
  end

  assign reg_eq  = (ent_reg == req_reg);
  assign tag_eq  = reg_eq && (ent_addr == req_addr) && (ent_size == req_size);
  assign snp_hit = ent_valid && snp_valid && (snp_lo < ent_hi) && (ent_lo < snp_hi);

endmodule

// File: rtl/alt_alloc_sel.sv
module alt_alloc_sel #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] reg_hit,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               use_victim
);

  logic             got_reg, got_free;
  logic [IDX_W-1:0] reg_idx, free_idx;

  always_comb begin
    got_reg  = 1'b0;
    got_free = 1'b0;
    reg_idx  = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!got_reg && reg_hit[i]) begin
        got_reg = 1'b1;
        reg_idx = IDX_W'(i);
      end
      if (!got_free && !live[i]) begin
        got_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Priority: the register's own entry, then the lowest free slot, then the victim.
  always_comb begin
    use_victim = 1'b0;
    if (got_reg)       sel_idx = reg_idx;
    else if (got_free) sel_idx = free_idx;
    else begin
      sel_idx    = rr_ptr;
      use_victim = 1'b1;
    end
  end

endmodule

// File: rtl/adv_load_tracker.sv
module adv_load_tracker
  import alt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 4,
  parameter int REG_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              force_miss_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [REG_W-1:0]  req_reg_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_nonspec_i,
  input  logic              req_defer_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [SIZE_W-1:0] snp_size_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_load_o,
  output logic              rsp_keep_o,
  output logic              rsp_base_upd_o,
  output logic              rsp_acq_o
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // Reset synchronizer: asserts at once, releases on the second clock edge.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Table state.
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][REG_W-1:0]  ent_reg_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr_q;
  logic [ENTRIES-1:0][SIZE_W-1:0] ent_size_q;
  logic [IDX_W-1:0]               rr_q, rr_d;

  // Per-entry comparison results.
  logic [ENTRIES-1:0] reg_eq, tag_eq, snp_kill;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      alt_entry_cmp #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .REG_W  (REG_W)
      ) u_cmp (
        .ent_valid (valid_q[g]),
        .ent_reg   (ent_reg_q[g]),
        .ent_addr  (ent_addr_q[g]),
        .ent_size  (ent_size_q[g]),
        .req_reg   (req_reg_i),
        .req_addr  (req_addr_i),
        .req_size  (req_size_i),
        .snp_valid (snp_valid_i),
        .snp_addr  (snp_addr_i),
        .snp_size  (snp_size_i),
        .reg_eq    (reg_eq[g]),
        .tag_eq    (tag_eq[g]),
        .snp_hit   (snp_kill[g])
      );
    end
  endgenerate

  // The store is applied before the lookup; a flush hides the whole table.
  logic [ENTRIES-1:0] live, live_reg, live_match;
  logic               is_adv, is_chk, is_clr, any_match, hit;

  always_comb begin
    live       = flush_i ? '0 : (valid_q & ~snp_kill);
    live_reg   = live & reg_eq;
    live_match = live & tag_eq;
    any_match  = |live_match;
    is_adv     = op_is_adv(req_op_i);
    is_chk     = op_is_chk(req_op_i);
    is_clr     = op_is_clr(req_op_i);
    hit        = req_valid_i && is_chk && any_match && !force_miss_i;
  end

  // Responses.
  always_comb begin
    rsp_valid_o    = req_valid_i;
    rsp_hit_o      = hit;
    rsp_keep_o     = hit;
    rsp_base_upd_o = req_valid_i && is_chk;
    rsp_acq_o      = req_valid_i && ((req_op_i == OP_CHK_ACQ) || (req_op_i == OP_ORD_LOAD));
    if (!req_valid_i)  rsp_load_o = 1'b0;
    else if (is_chk)   rsp_load_o = !hit;
    else if (is_adv)   rsp_load_o = !req_defer_i;
    else               rsp_load_o = 1'b1;
  end

  // Allocation and removal decisions.
  logic               do_alloc, purge_en, clear_en, use_victim;
  logic [IDX_W-1:0]   sel_idx;
  logic [ENTRIES-1:0] wr_en;

  alt_alloc_sel #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_sel (
    .live       (live),
    .reg_hit    (live_reg),
    .rr_ptr     (rr_q),
    .sel_idx    (sel_idx),
    .use_victim (use_victim)
  );

  always_comb begin
    purge_en = req_valid_i && !flush_i && is_adv && req_defer_i;
    clear_en = hit && is_clr;
    do_alloc = req_valid_i && !flush_i &&
               ((is_adv && !req_defer_i) ||
                ((req_op_i == OP_CHK_KEEP) && !hit && !req_nonspec_i));
  end

  always_comb begin
    valid_d = live;
    if (purge_en) valid_d = valid_d & ~live_reg;
    if (clear_en) valid_d = valid_d & ~live_match;
    wr_en = '0;
    if (do_alloc) begin
      wr_en[sel_idx]   = 1'b1;
      valid_d[sel_idx] = 1'b1;
    end
    if (flush_i)                    rr_d = '0;
    else if (do_alloc && use_victim) rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    else                            rr_d = rr_q;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wr_en[g]) begin
          ent_reg_q[g]  <= req_reg_i;
          ent_addr_q[g] <= req_addr_i;
          ent_size_q[g] <= req_size_i;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/alt_checker.sv
module alt_checker
  import alt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush_i,
  input logic                            force_miss_i,
  input logic                            req_valid_i,
  input logic [2:0]                      req_op_i,
  input logic [REG_W-1:0]                req_reg_i,
  input logic                            req_defer_i,
  input logic                            rsp_hit_o,
  input logic                            rsp_load_o,
  input logic                            rsp_keep_o,
  input logic                            rsp_base_upd_o,
  input logic                            rsp_acq_o,
  input logic [ENTRIES-1:0]              valid_q,
  input logic [ENTRIES-1:0][REG_W-1:0]   ent_reg_q
);

  logic [REG_W-1:0] last_reg_q;
  logic             stale_entry;

  always_ff @(posedge clk) last_reg_q <= req_reg_i;

  always_comb begin
    stale_entry = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid_q[i] && ent_reg_q[i] == last_reg_q) stale_entry = 1'b1;
  end

  // R3, R5: a hit never asks for memory and always preserves the destination.
  p_hit_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && rsp_hit_o) |-> (!rsp_load_o && rsp_keep_o));

  // R2: a deferred advanced load leaves no entry for its register.
  p_defer_purge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_is_adv(req_op_i) && req_defer_i && !flush_i) |=> !stale_entry);

  // R7: forced misses.
  p_force_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && force_miss_i) |-> !rsp_hit_o);

  // R8: base update tracks check codes.
  p_base_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |-> (rsp_base_upd_o == op_is_chk(req_op_i)));

  // R6: ordered clearing check carries acquire.
  p_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i == OP_CHK_ACQ) |-> rsp_acq_o);

  // R11: flush empties the table.
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

endmodule

bind adv_load_tracker alt_checker #(
  .ENTRIES (ENTRIES),
  .REG_W   (REG_W)
) u_alt_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush_i        (flush_i),
  .force_miss_i   (force_miss_i),
  .req_valid_i    (req_valid_i),
  .req_op_i       (req_op_i),
  .req_reg_i      (req_reg_i),
  .req_defer_i    (req_defer_i),
  .rsp_hit_o      (rsp_hit_o),
  .rsp_load_o     (rsp_load_o),
  .rsp_keep_o     (rsp_keep_o),
  .rsp_base_upd_o (rsp_base_upd_o),
  .rsp_acq_o      (rsp_acq_o),
  .valid_q        (valid_q),
  .ent_reg_q      (ent_reg_q)
);

// File: tb/adv_load_tracker_bench.sv
module adv_load_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, force_miss_i, req_valid_i, req_nonspec_i, req_defer_i, snp_valid_i;
  logic [2:0]  req_op_i;
  logic [6:0]  req_reg_i;
  logic [31:0] req_addr_i, snp_addr_i;
  logic [3:0]  req_size_i, snp_size_i;
  logic        rsp_valid_o, rsp_hit_o, rsp_load_o, rsp_keep_o, rsp_base_upd_o, rsp_acq_o;

  int checks = 0;
  int fails  = 0;

  // Response codes {hit, load, keep, base_upd, acq}.
  localparam logic [4:0] ADV_OK   = 5'b01000;
  localparam logic [4:0] ADV_DEF  = 5'b00000;
  localparam logic [4:0] CHK_HIT  = 5'b10110;
  localparam logic [4:0] CHK_MISS = 5'b01010;
  localparam logic [4:0] ACQ_HIT  = 5'b10111;
  localparam logic [4:0] ACQ_MISS = 5'b01011;
  localparam logic [4:0] LD_PLAIN = 5'b01000;
  localparam logic [4:0] LD_ORD   = 5'b01001;

  always #2 clk = ~clk;

  adv_load_tracker u_adv_load_tracker (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .force_miss_i(force_miss_i),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_reg_i(req_reg_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .req_nonspec_i(req_nonspec_i),
    .req_defer_i(req_defer_i), .snp_valid_i(snp_valid_i), .snp_addr_i(snp_addr_i),
    .snp_size_i(snp_size_i), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
    .rsp_load_o(rsp_load_o), .rsp_keep_o(rsp_keep_o), .rsp_base_upd_o(rsp_base_upd_o),
    .rsp_acq_o(rsp_acq_o)
  );

  logic [4:0] got;

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush_i = 0; force_miss_i = 0; req_valid_i = 0; req_op_i = 0; req_reg_i = 0;
    req_addr_i = 0; req_size_i = 0; req_nonspec_i = 0; req_defer_i = 0;
    snp_valid_i = 0; snp_addr_i = 0; snp_size_i = 0;
  endtask

  // Drive after the falling edge, sample 1 ns later, commit at the rising edge.
  task automatic op_snp(input logic [2:0] op, input logic [6:0] r, input logic [31:0] a,
                        input logic [3:0] s, input logic ns, input logic df,
                        input logic sv, input logic [31:0] sa, input logic [3:0] ss);
    @(negedge clk);
    req_valid_i = 1; req_op_i = op; req_reg_i = r; req_addr_i = a; req_size_i = s;
    req_nonspec_i = ns; req_defer_i = df;
    snp_valid_i = sv; snp_addr_i = sa; snp_size_i = ss;
    #1;
    got = {rsp_hit_o, rsp_load_o, rsp_keep_o, rsp_base_upd_o, rsp_acq_o};
    @(posedge clk);
    #0.5;
    idle_inputs();
  endtask

  task automatic op1(input logic [2:0] op, input logic [6:0] r, input logic [31:0] a,
                     input logic [3:0] s, input logic ns, input logic df);
    op_snp(op, r, a, s, ns, df, 1'b0, 32'h0, 4'h0);
  endtask

  task automatic flush_table();
    @(negedge clk);
    flush_i = 1;
    @(posedge clk);
    #0.5;
    flush_i = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 idle after reset", {rsp_valid_o, rsp_hit_o, rsp_load_o, rsp_keep_o, rsp_acq_o}, 5'b0);
    op1(3'd4, 7'd1, 32'h40, 4'd8, 0, 0);
    check("R11 empty after reset", got, CHK_MISS);
    op1(3'd0, 7'd1, 32'h40, 4'd8, 0, 0);
    check("R8 plain load", got, LD_PLAIN);
  endtask

  task automatic t_adv_check();
    flush_table();
    op1(3'd1, 7'd20, 32'h100, 4'd8, 0, 0);
    check("R1 advanced load", got, ADV_OK);
    op1(3'd3, 7'd20, 32'h100, 4'd8, 0, 0);
    check("R3 keep check hit", got, CHK_HIT);
    op1(3'd3, 7'd20, 32'h100, 4'd8, 0, 0);
    check("R3 entry retained", got, CHK_HIT);
    op1(3'd2, 7'd21, 32'h180, 4'd4, 0, 0);
    check("R1 spec advanced load", got, ADV_OK);
    op1(3'd4, 7'd21, 32'h180, 4'd4, 0, 0);
    check("R1 spec advanced allocated", got, CHK_HIT);
  endtask

  task automatic t_defer();
    flush_table();
    op1(3'd1, 7'd7, 32'h500, 4'd8, 0, 0);
    op1(3'd2, 7'd7, 32'h600, 4'd8, 0, 1);
    check("R2 deferred response", got, ADV_DEF);
    op1(3'd4, 7'd7, 32'h500, 4'd8, 0, 0);
    check("R2 entry purged", got, CHK_MISS);
    op1(3'd1, 7'd8, 32'h680, 4'd8, 0, 1);
    op1(3'd4, 7'd8, 32'h680, 4'd8, 0, 0);
    check("R2 deferred allocates nothing", got, CHK_MISS);
  endtask

  task automatic t_nc_miss();
    flush_table();
    op1(3'd3, 7'd9, 32'h700, 4'd2, 1, 0);
    check("R4 miss nonspec", got, CHK_MISS);
    op1(3'd3, 7'd9, 32'h700, 4'd2, 1, 0);
    check("R4 nonspec allocated nothing", got, CHK_MISS);
    op1(3'd3, 7'd9, 32'h700, 4'd2, 0, 0);
    check("R4 miss spec", got, CHK_MISS);
    op1(3'd3, 7'd9, 32'h700, 4'd2, 0, 0);
    check("R4 miss allocated", got, CHK_HIT);
  endtask

  task automatic t_clear();
    flush_table();
    op1(3'd1, 7'd11, 32'h800, 4'd8, 0, 0);
    op1(3'd4, 7'd11, 32'h800, 4'd8, 0, 0);
    check("R5 clear hit", got, CHK_HIT);
    op1(3'd4, 7'd11, 32'h800, 4'd8, 0, 0);
    check("R5 entry removed", got, CHK_MISS);
    op1(3'd4, 7'd11, 32'h800, 4'd8, 0, 0);
    check("R5 miss allocated nothing", got, CHK_MISS);
  endtask

  task automatic t_acq();
    flush_table();
    op1(3'd1, 7'd12, 32'h880, 4'd4, 0, 0);
    op1(3'd5, 7'd12, 32'h880, 4'd4, 0, 0);
    check("R6 ordered clear hit", got, ACQ_HIT);
    op1(3'd5, 7'd12, 32'h880, 4'd4, 0, 0);
    check("R6 ordered clear removed", got, ACQ_MISS);
    op1(3'd6, 7'd12, 32'h880, 4'd4, 0, 0);
    check("R6 ordered load", got, LD_ORD);
    op1(3'd7, 7'd12, 32'h880, 4'd4, 0, 0);
    check("R8 code 7 plain load", got, LD_PLAIN);
  endtask

  task automatic t_force();
    flush_table();
    op1(3'd1, 7'd13, 32'h900, 4'd8, 0, 0);
    force_miss_i = 1;
    op1(3'd4, 7'd13, 32'h900, 4'd8, 0, 0);
    check("R7 forced clear miss", got, CHK_MISS);
    force_miss_i = 1;
    op1(3'd3, 7'd13, 32'h900, 4'd8, 0, 0);
    check("R7 forced keep miss", got, CHK_MISS);
    op1(3'd4, 7'd13, 32'h900, 4'd8, 0, 0);
    check("R7 entry survived forced miss", got, CHK_HIT);
  endtask

  task automatic t_match();
    flush_table();
    op1(3'd1, 7'd14, 32'hA00, 4'd4, 0, 0);
    op1(3'd4, 7'd15, 32'hA00, 4'd4, 0, 0);
    check("R9 register differs", got, CHK_MISS);
    op1(3'd4, 7'd14, 32'hA04, 4'd4, 0, 0);
    check("R9 address differs", got, CHK_MISS);
    op1(3'd4, 7'd14, 32'hA00, 4'd8, 0, 0);
    check("R9 size differs", got, CHK_MISS);
    op1(3'd4, 7'd14, 32'hA00, 4'd4, 0, 0);
    check("R9 exact match", got, CHK_HIT);
  endtask

  task automatic t_snoop();
    flush_table();
    op1(3'd1, 7'd30, 32'h100, 4'd8, 0, 0);
    op_snp(3'd3, 7'd30, 32'h100, 4'd8, 0, 0, 1'b1, 32'h108, 4'd4);
    check("R10 store just above range", got, CHK_HIT);
    op_snp(3'd3, 7'd30, 32'h100, 4'd8, 0, 0, 1'b1, 32'h0FC, 4'd4);
    check("R10 store just below range", got, CHK_HIT);
    op_snp(3'd3, 7'd30, 32'h100, 4'd8, 0, 0, 1'b1, 32'h107, 4'd1);
    check("R10 same-cycle store first", got, CHK_MISS);
    op1(3'd3, 7'd30, 32'h100, 4'd8, 0, 0);
    check("R10 miss refilled entry", got, CHK_HIT);
    op_snp(3'd0, 7'd0, 32'h0, 4'd0, 0, 0, 1'b1, 32'h0FE, 4'd4);
    op1(3'd4, 7'd30, 32'h100, 4'd8, 0, 0);
    check("R10 overlapping store dropped entry", got, CHK_MISS);
  endtask

  task automatic t_flush();
    flush_table();
    op1(3'd1, 7'd3, 32'hC00, 4'd8, 0, 0);
    @(negedge clk);
    flush_i = 1;
    req_valid_i = 1; req_op_i = 3'd3; req_reg_i = 7'd3; req_addr_i = 32'hC00; req_size_i = 4'd8;
    #1;
    got = {rsp_hit_o, rsp_load_o, rsp_keep_o, rsp_base_upd_o, rsp_acq_o};
    @(posedge clk);
    #0.5;
    idle_inputs();
    check("R11 lookup during flush", got, CHK_MISS);
    op1(3'd4, 7'd3, 32'hC00, 4'd8, 0, 0);
    check("R11 flush cleared and blocked alloc", got, CHK_MISS);
  endtask

  task automatic t_alloc();
    flush_table();
    op1(3'd1, 7'd5, 32'h300, 4'd4, 0, 0);
    op1(3'd1, 7'd5, 32'h400, 4'd4, 0, 0);
    op1(3'd4, 7'd5, 32'h300, 4'd4, 0, 0);
    check("R12 overwrite dropped old address", got, CHK_MISS);
    op1(3'd4, 7'd5, 32'h400, 4'd4, 0, 0);
    check("R12 overwrite kept new address", got, CHK_HIT);
    flush_table();
    for (int i = 0; i < 8; i++) op1(3'd1, 7'(40 + i), 32'h1000 + 32'(i * 16), 4'd8, 0, 0);
    op1(3'd1, 7'd50, 32'h2000, 4'd8, 0, 0);
    op1(3'd4, 7'd41, 32'h1010, 4'd8, 0, 0);
    check("R12 second entry kept", got, CHK_HIT);
    op1(3'd4, 7'd40, 32'h1000, 4'd8, 0, 0);
    check("R12 first victim evicted", got, CHK_MISS);
    op1(3'd1, 7'd51, 32'h2100, 4'd8, 0, 0);
    op1(3'd1, 7'd52, 32'h2200, 4'd8, 0, 0);
    op1(3'd4, 7'd51, 32'h2100, 4'd8, 0, 0);
    check("R12 pointer advanced to entry 1", got, CHK_MISS);
    op1(3'd4, 7'd42, 32'h1020, 4'd8, 0, 0);
    check("R12 third entry kept", got, CHK_HIT);
    op1(3'd4, 7'd50, 32'h2000, 4'd8, 0, 0);
    check("R12 victim slot holds new register", got, CHK_HIT);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    repeat (3) @(posedge clk);
    t_reset();
    t_adv_check();
    t_defer();
    t_nc_miss();
    t_clear();
    t_acq();
    t_force();
    t_match();
    t_snoop();
    t_flush();
    t_alloc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule